// File: doc/BRIEF.md
# Firmware Version String Reader

This block fetches a zero-terminated text string that a device exposes through a single register of a register window. On a start pulse it records the active locality and forms the register address from it. It then sends one single-byte write of zero to that address, which makes the device restart the string at its first character. After that it reads the same address again and again, four bytes per read, and appends the characters to an internal buffer.

The reads stop at the first zero byte in a chunk, or once the buffer holds its maximum of 64 characters. At the end the block writes a zero after the last character it kept, publishes the character count and raises a done level. A host reads the characters back one at a time through an index port.

The block talks to the transport through a generic request/acknowledge register interface. It holds a request steady until the responder acknowledges it, and the responder returns read data along with the acknowledge.

Top module: `fw_version_fetch`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `req_valid` are 0 and `str_len` is 0.
- R2: After a start the first request is a write (`req_write`=1) of size 1 carrying `req_wdata`=0. Its address is 16'h0F90 OR (locality << 12), using the locality sampled at the start.
- R3: Once the write is acknowledged, every later request is a read of size 4 to the same address. A request keeps its address and direction unchanged until `req_ack` is seen.
- R4: In read data, the byte in bits [8b+7:8b] is character b of the chunk, with b=0 first. Characters are stored at consecutive indices from 0 upward, across chunks, in the order they arrive.
- R5: The first zero byte in a chunk ends the whole read. That byte and every byte after it in the chunk are not stored.
- R6: A further read is issued only when all four bytes of the previous chunk were non-zero and fewer than 64 characters are held.
- R7: The read ends when 64 characters are held, even if no zero byte has arrived. `str_len` never exceeds 64.
- R8: After completion, `rd_char` at index `str_len` reads as 0, and indices below it return the stored characters.
- R9: `done` rises in the cycle after the final acknowledge. At that point `busy` and `req_valid` are 0, and `str_len` then stays unchanged until the next start.
- R10: A start pulse while busy is ignored: the address, the count and the sequence continue unaffected. A change on `locality` after the start has no effect.
- R11: An acknowledge that arrives while no request is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle start pulse, taken only when idle |
| locality | input | 4 | Active locality, sampled at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Result valid; cleared by the next start |
| str_len | output | 7 | Number of characters collected (0..64) |
| rd_idx | input | 7 | Buffer index to read back |
| rd_char | output | 8 | Character at `rd_idx` (0 beyond the buffer) |
| req_valid | output | 1 | Register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Register address |
| req_size | output | 3 | Transfer size in bytes (1 or 4) |
| req_wdata | output | 8 | Write data byte |
| req_ack | input | 1 | One-cycle completion of the pending request |
| req_rdata | input | 32 | Read data, valid with `req_ack` |

## Verification
The first request appears one cycle after the start pulse. Each following request, whether the first read after the rewind or a further chunk, is already present in the cycle after the previous acknowledge. `done` and the final `str_len` are due in that same cycle after the last acknowledge. The bench drives its stimulus on the falling edge and samples on the next falling edge, so every result is checked exactly one register stage after the input that caused it. During an acknowledge delay the request must simply hold; the bench checks the request at the moment it answers, and a bound property checks that the request stays steady while it waits. `rd_char` is a plain combinational read, so it is sampled shortly after `rd_idx` changes.

// File: rtl/fw_version_fetch.sv
module fw_version_fetch #(
  parameter int MAX_CHARS = 64,
  parameter int CHUNK = 4,
  parameter int LOC_W = 4,
  parameter int ADDR_W = 16,
  parameter int LOC_SHIFT = 12,
  parameter logic [15:0] BASE_ADDR = 16'h0F90,
  parameter int LEN_W = $clog2(MAX_CHARS + 1),
  parameter int SIZE_W = $clog2(CHUNK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [LOC_W-1:0]     locality,
  output logic                 busy,
  output logic                 done,
  output logic [LEN_W-1:0]     str_len,
  input  logic [LEN_W-1:0]     rd_idx,
  output logic [7:0]           rd_char,
  output logic                 req_valid,
  output logic                 req_write,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [SIZE_W-1:0]    req_size,
  output logic [7:0]           req_wdata,
  input  logic                 req_ack,
  input  logic [8*CHUNK-1:0]   req_rdata
);

  localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_CHARS);

  typedef enum logic [1:0] {S_IDLE, S_REWIND, S_FETCH} state_t;

  state_t           state_q;
  logic [LOC_W-1:0] loc_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic [7:0]       mem_q [MAX_CHARS+1];

  logic [SIZE_W-1:0] lead;
  logic [LEN_W-1:0]  room, take, new_len;
  logic              finish;

  always_comb begin
    lead = SIZE_W'(CHUNK);
    for (int b = CHUNK - 1; b >= 0; b--)
      if (req_rdata[8*b +: 8] == 8'h00) lead = SIZE_W'(b);
  end

  assign room    = CAP - len_q;
  assign take    = (LEN_W'(lead) < room) ? LEN_W'(lead) : room;
  assign new_len = len_q + take;
  assign finish  = (lead != SIZE_W'(CHUNK)) || (new_len == CAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      loc_q   <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_REWIND;
          loc_q   <= locality;
          len_q   <= '0;
          done_q  <= 1'b0;
        end
        S_REWIND: if (req_ack) state_q <= S_FETCH;
        S_FETCH: if (req_ack) begin
          len_q <= new_len;
          if (finish) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state_q == S_FETCH && req_ack) begin
      for (int b = 0; b < CHUNK; b++)
        if (LEN_W'(b) < take) mem_q[len_q + LEN_W'(b)] <= req_rdata[8*b +: 8];
      if (finish) mem_q[new_len] <= 8'h00;
    end
  end

  assign busy      = (state_q != S_IDLE);
  assign done      = done_q;
  assign str_len   = len_q;
  assign rd_char   = (rd_idx <= CAP) ? mem_q[rd_idx] : 8'h00;
  assign req_valid = busy;
  assign req_write = (state_q == S_REWIND);
  assign req_size  = req_write ? SIZE_W'(1) : SIZE_W'(CHUNK);
  assign req_wdata = 8'h00;
  assign req_addr  = BASE_ADDR[ADDR_W-1:0] | (ADDR_W'(loc_q) << LOC_SHIFT);

endmodule

// File: rtl/fw_version_fetch_chk.sv
module fw_version_fetch_chk #(
  parameter int MAX_CHARS = 64,
  parameter int CHUNK = 4,
  parameter int ADDR_W = 16,
  parameter int LOC_SHIFT = 12,
  parameter logic [15:0] BASE_ADDR = 16'h0F90,
  parameter int LEN_W = 7,
  parameter int SIZE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [LEN_W-1:0]  str_len,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [SIZE_W-1:0] req_size,
  input logic [7:0]        req_wdata,
  input logic              req_ack
);

  // R2
  rewind_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |-> req_wdata == 8'h00 && req_size == SIZE_W'(1));

  // R3
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_write |-> req_size == SIZE_W'(CHUNK));

  // R2
  addr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[LOC_SHIFT-1:0] == BASE_ADDR[LOC_SHIFT-1:0]);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ack |=> req_valid && $stable(req_addr) && $stable(req_write));

  // R10
  addr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy || $stable(req_addr));

  // R7
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    str_len <= LEN_W'(MAX_CHARS));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid);

  // R9
  len_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> $stable(str_len));

endmodule

bind fw_version_fetch fw_version_fetch_chk #(
  .MAX_CHARS(MAX_CHARS), .CHUNK(CHUNK), .ADDR_W(ADDR_W), .LOC_SHIFT(LOC_SHIFT),
  .BASE_ADDR(BASE_ADDR), .LEN_W(LEN_W), .SIZE_W(SIZE_W)
) u_chk (.*);

// File: tb/fw_version_fetch_tb.sv
`timescale 1ns/1ps
module fw_version_fetch_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  locality = 4'h0;
  logic        busy, done;
  logic [6:0]  str_len;
  logic [6:0]  rd_idx = '0;
  logic [7:0]  rd_char;
  logic        req_valid, req_write;
  logic [15:0] req_addr;
  logic [2:0]  req_size;
  logic [7:0]  req_wdata;
  logic        req_ack = 1'b0;
  logic [31:0] req_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] model [128];

  always #4 clk = ~clk;

  fw_version_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .locality(locality),
    .busy(busy), .done(done), .str_len(str_len), .rd_idx(rd_idx), .rd_char(rd_char),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_ack(req_ack), .req_rdata(req_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic session(input int slen, input int dly, input logic [3:0] loc, input bit mid);
    int ptr = 0, reads = 0, writes = 0, guard = 0;
    int exp_len = (slen < 64) ? slen : 64;
    int exp_reads = (slen < 64) ? slen / 4 + 1 : 16;
    logic [15:0] exp_addr = 16'h0F90 | (16'(loc) << 12);
    for (int i = 0; i < 128; i++)
      model[i] = (i < slen) ? 8'(8'h21 + ((i * 13 + slen) % 90)) : (i == slen ? 8'h00 : 8'hA5);
    locality = loc;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    locality = loc ^ 4'h5;
    chk("R2 busy after start", busy, 1);
    while (req_valid && guard < 100) begin
      guard++;
      repeat (dly) @(negedge clk);
      if (mid && reads == 1) begin
        start = 1'b1; locality = ~loc;
        @(negedge clk);
        start = 1'b0;
      end
      if (req_write) begin
        chk("R2 write first", writes + reads, 0);
        chk("R2 write addr", req_addr, exp_addr);
        chk("R2 write size", req_size, 1);
        chk("R2 write data", req_wdata, 0);
        ptr = 0; writes++;
        req_rdata = 32'hDEADBEEF;
      end else begin
        chk("R3 read after write", writes, 1);
        chk(mid ? "R10 read addr" : "R3 read addr", req_addr, exp_addr);
        chk("R3 read size", req_size, 4);
        req_rdata = {model[ptr+3], model[ptr+2], model[ptr+1], model[ptr]};
        ptr += 4; reads++;
      end
      req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0;
      req_rdata = '0;
    end
    chk("R6 read count", reads, exp_reads);
    chk("R9 done after last ack", done, 1);
    chk("R9 idle at done", busy, 0);
    chk(slen >= 64 ? "R7 capped length" : "R5 length at zero byte", str_len, exp_len);
    for (int i = 0; i <= exp_len; i++) begin
      rd_idx = 7'(i);
      #1;
      if (i < exp_len) chk("R4 stored char", rd_char, model[i]);
      else chk("R8 terminator", rd_char, 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 req_valid", req_valid, 0);
    chk("R1 str_len", str_len, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int L = 0; L <= 70; L++) begin
      session(L, L % 3, 4'(L % 16), (L % 5) == 2 && L >= 8);
      // R11: stray acknowledge while idle
      req_rdata = 32'h41424344; req_ack = 1'b1;
      @(negedge clk);
      req_ack = 1'b0; req_rdata = '0;
      @(negedge clk);
      chk("R11 stray ack len", str_len, (L < 64) ? L : 64);
      chk("R11 stray ack done", done, 1);
      chk("R11 stray ack no request", req_valid, 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule